// File: doc/BRIEF.md
# ATA Command and PIO Data Engine

This block serves one channel of a storage controller. It accepts the command byte that the host writes and decodes it against the type of the drive that is currently selected. It updates the status and error bytes and the drive's sector and cylinder registers as each command requires, and it raises the channel interrupt. It also moves 16-bit programmed-I/O words between the host data port and a 2048-byte transfer buffer. A transfer index and a transfer length govern every data-port access.

For a packet command, the data port collects a 12-byte command packet. Once the last byte is in, the block pulses a strobe so that a downstream packet handler can decode the packet. The handler reads the buffer through a private read port. The handler, or an identify-data source, writes the buffer through a fill port. Reads past the end of a transfer return zero bytes, and the data-request flag drops as soon as the final word has been read.

Top module: `ata_cmd_pio_engine`

## Requirements
- R1: After synchronous reset the block holds the following values: status 0x50, error 0x01, sector count 1, sector number 1, cylinder 0x0000, irq 0, pkt_ready 0, transfer length 0.
- R2: Command 0xA0 with drive_kind 1 (packet device) sets sector count to 1. It clears status bits 7 (busy), 5 (write fault) and 0 (error), sets bit 3 (data request) and leaves the other bits unchanged. It sets the transfer index to 0 and the transfer length to 12. It requests no interrupt.
- R3: An abort sets status to 0x41 and error to 0x04 and requests an interrupt. Any of the following aborts: command 0xA0 when drive_kind is not 1, command 0xEC when drive_kind is 0 (disk), or any code other than 0xA0, 0xA1 and 0xEC. An abort caused by 0xEC on a disk leaves the sector and cylinder registers unchanged.
- R4: Command 0xA1 sets status to 0x58 and error to 0x00. It sets the transfer index to 0 and the transfer length to 512, and requests an interrupt.
- R5: Command 0xEC when drive_kind is not 0 resets the drive registers and then aborts as in R3. The reset sets sector count to 1, sector number to 1 and the transfer length to 0. It sets the cylinder to 0xEB14 for a packet device (drive_kind 1) and to 0x0000 for an absent drive (drive_kind 2).
- R6: A data-port write while index < length stores data_wdata at buffer word address index/2, with the low byte at the even byte offset. It then advances the index by 2, or sets it to the length if fewer than 2 bytes remain. A write with index >= length changes neither the buffer nor the index.
- R7: pkt_ready is high for exactly one cycle, in the cycle after a data-port write that brings the index up to the length, provided the last accepted command was 0xA0.
- R8: While data_re is high, data_rdata shows, in the same cycle, the buffer word at index/2. Any byte whose offset is at or beyond the length reads as zero. A read with index < length advances the index as in R6.
- R9: A data-port read that brings the index up to the length clears status bit 3 (data request) at that clock edge.
- R10: irq is a one-cycle pulse in the cycle after a command that requests an interrupt. The pulse is produced only if irq_disable was 0 in the command cycle.
- R11: A fill write stores fill_data at buffer word fill_addr. If a data-port write hits the same word in the same cycle, the data-port value is kept.
- R12: hnd_rdata shows the buffer word at hnd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command code |
| drive_kind | input | 2 | Selected drive: 0 disk, 1 packet device, 2 absent |
| irq_disable | input | 1 | Interrupt mask bit |
| data_we | input | 1 | Data-port write strobe |
| data_wdata | input | 16 | Data-port write word |
| data_re | input | 1 | Data-port read strobe |
| data_rdata | output | 16 | Data-port read word, zero-padded past the length |
| fill_we | input | 1 | Buffer fill write strobe |
| fill_addr | input | 10 | Buffer fill word address |
| fill_data | input | 16 | Buffer fill word |
| hnd_addr | input | 10 | Handler read word address |
| hnd_rdata | output | 16 | Handler read word |
| status | output | 8 | Status byte |
| error | output | 8 | Error byte |
| sector_count | output | 8 | Sector count register |
| sector_num | output | 8 | Sector number register |
| cylinder | output | 16 | Cylinder register |
| irq | output | 1 | Interrupt pulse |
| pkt_ready | output | 1 | Packet received strobe |

## Verification
The assertions assume that the host never strobes data_re and data_we in the same cycle. They also assume that no command write coincides with a data-port access. The DRQ and padding properties are written only for read cycles that meet these two conditions. The pulse property on pkt_ready assumes that a new packet command is never issued and completed within a single cycle, which holds because the packet spans several words. The bench drives each strobe on its own in separate cycles, always at the falling edge. It issues the one deliberate data/fill overlap to a word that no assertion observes.

// File: rtl/ata_pio_pkg.sv
// Shared constants for the ATA command and PIO data engine.
// Assumes 8-bit command/status bytes and a 16-bit data port.
package ata_pio_pkg;
    localparam logic [1:0] KIND_DISK   = 2'd0;
    localparam logic [1:0] KIND_PACKET = 2'd1;
    localparam logic [1:0] KIND_ABSENT = 2'd2;

    localparam logic [7:0] OP_PACKET    = 8'hA0;
    localparam logic [7:0] OP_PKT_IDENT = 8'hA1;
    localparam logic [7:0] OP_IDENT     = 8'hEC;

    localparam int ST_BSY = 7;
    localparam int ST_DF  = 5;
    localparam int ST_DRQ = 3;
    localparam int ST_ERR = 0;

    localparam logic [7:0]  STATUS_RESET   = 8'h50;
    localparam logic [7:0]  ERROR_RESET    = 8'h01;
    localparam logic [7:0]  STATUS_ABORT   = 8'h41;
    localparam logic [7:0]  ERROR_ABORT    = 8'h04;
    localparam logic [7:0]  STATUS_IDENT   = 8'h58;
    localparam logic [15:0] CYL_PACKET_SIG = 16'hEB14;
endpackage

// File: rtl/ata_xfer_buffer.sv
// Word-wide transfer buffer.
// Provides two write ports: the data port wins over the fill port when both
// target the same word. Provides two asynchronous read ports: the data port
// and the handler. Holds no reset; the contents are defined only after a write.
module ata_xfer_buffer #(
    parameter int WORDS = 1024,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [15:0]   a_data,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [15:0]   b_data,
    input  logic [AW-1:0] r_addr,
    output logic [15:0]   r_data,
    input  logic [AW-1:0] h_addr,
    output logic [15:0]   h_data
);
    logic [15:0] mem [WORDS];

    // Write both ports; the fill write yields on an address collision.
    always_ff @(posedge clk) begin
        if (a_we)
            mem[a_addr] <= a_data;
        if (b_we && !(a_we && (a_addr == b_addr)))
            mem[b_addr] <= b_data;
    end

    // Asynchronous read for the data port and the handler.
    assign r_data = mem[r_addr];
    assign h_data = mem[h_addr];
endmodule

// File: rtl/ata_xfer_ctrl.sv
// Transfer index/length tracker.
// Advances the byte index by one 16-bit word per accepted access, saturating
// at the length. Flags the read that ends a transfer, pulses pkt_ready when a
// packet-mode write fills the packet, and reports which read bytes lie
// inside the transfer. Assumes the data port is never read and written in
// the same cycle; if it is, the write is taken.
module ata_xfer_ctrl #(
    parameter int LEN_W = 12,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             data_we,
    input  logic             data_re,
    input  logic             pkt_mode,
    output logic [LEN_W-1:0] idx,
    output logic [LEN_W-1:0] len,
    output logic [AW-1:0]    word_addr,
    output logic             wr_take,
    output logic             rd_done,
    output logic             lo_valid,
    output logic             hi_valid,
    output logic             pkt_ready
);
    logic             active;
    logic             rd_take;
    logic [LEN_W-1:0] step_idx;

    // Decide whether an access is accepted and where the index goes next.
    always_comb begin
        active    = idx < len;
        wr_take   = data_we && active && !load;
        rd_take   = data_re && !data_we && active && !load;
        step_idx  = ((len - idx) > LEN_W'(1)) ? idx + LEN_W'(2) : len;
        rd_done   = rd_take && (step_idx == len);
        lo_valid  = active;
        hi_valid  = (idx + LEN_W'(1)) < len;
        word_addr = idx[AW:1];
    end

    // Index, length and packet-ready strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            len       <= '0;
            pkt_ready <= 1'b0;
        end else begin
            pkt_ready <= wr_take && pkt_mode && (step_idx == len);
            if (load) begin
                idx <= '0;
                len <= load_len;
            end else if (wr_take || rd_take) begin
                idx <= step_idx;
            end
        end
    end
endmodule

// File: rtl/ata_cmd_decode.sv
// Command decoder and register owner.
// Applies each command's effect on status, error and drive registers; asks
// the transfer tracker to reload; issues the masked interrupt pulse; drops
// the data-request bit when the tracker reports the final read. A command
// write takes priority over a same-cycle end-of-read.
module ata_cmd_decode
    import ata_pio_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int PKT_BYTES   = 12,
    parameter int IDENT_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_byte,
    input  logic [1:0]       drive_kind,
    input  logic             irq_disable,
    input  logic             rd_done,
    output logic [7:0]       status,
    output logic [7:0]       error,
    output logic [7:0]       sector_count,
    output logic [7:0]       sector_num,
    output logic [15:0]      cylinder,
    output logic             irq,
    output logic             pkt_mode,
    output logic             load,
    output logic [LEN_W-1:0] load_len
);
    logic [7:0]  st_n, er_n, sc_n, sn_n;
    logic [15:0] cy_n;
    logic        pm_n, irq_req, abort;

    // Next-state decode of the command byte.
    always_comb begin
        st_n     = status;
        er_n     = error;
        sc_n     = sector_count;
        sn_n     = sector_num;
        cy_n     = cylinder;
        pm_n     = pkt_mode;
        irq_req  = 1'b0;
        abort    = 1'b0;
        load     = 1'b0;
        load_len = '0;
        if (cmd_we) begin
            pm_n = 1'b0;
            case (cmd_byte)
                OP_PACKET: begin
                    if (drive_kind == KIND_PACKET) begin
                        sc_n         = 8'd1;
                        st_n[ST_BSY] = 1'b0;
                        st_n[ST_DF]  = 1'b0;
                        st_n[ST_ERR] = 1'b0;
                        st_n[ST_DRQ] = 1'b1;
                        load         = 1'b1;
                        load_len     = LEN_W'(PKT_BYTES);
                        pm_n         = 1'b1;
                    end else begin
                        abort = 1'b1;
                    end
                end
                OP_PKT_IDENT: begin
                    st_n     = STATUS_IDENT;
                    er_n     = 8'h00;
                    load     = 1'b1;
                    load_len = LEN_W'(IDENT_BYTES);
                    irq_req  = 1'b1;
                end
                OP_IDENT: begin
                    if (drive_kind != KIND_DISK) begin
                        sc_n = 8'd1;
                        sn_n = 8'd1;
                        cy_n = (drive_kind == KIND_PACKET) ? CYL_PACKET_SIG : 16'h0000;
                        load = 1'b1;
                    end
                    abort = 1'b1;
                end
                default: abort = 1'b1;
            endcase
            if (abort) begin
                st_n    = STATUS_ABORT;
                er_n    = ERROR_ABORT;
                irq_req = 1'b1;
            end
        end else if (rd_done) begin
            st_n[ST_DRQ] = 1'b0;
        end
    end

    // Register update and masked interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status       <= STATUS_RESET;
            error        <= ERROR_RESET;
            sector_count <= 8'd1;
            sector_num   <= 8'd1;
            cylinder     <= 16'h0000;
            pkt_mode     <= 1'b0;
            irq          <= 1'b0;
        end else begin
            status       <= st_n;
            error        <= er_n;
            sector_count <= sc_n;
            sector_num   <= sn_n;
            cylinder     <= cy_n;
            pkt_mode     <= pm_n;
            irq          <= irq_req && !irq_disable;
        end
    end
endmodule

// File: rtl/ata_cmd_pio_engine.sv
// Top level: command decode, transfer tracking and transfer buffer for one
// channel. Assumes data_re and data_we are exclusive and that commands are
// not written in the same cycle as a data-port access.
module ata_cmd_pio_engine #(
    parameter int BUF_BYTES   = 2048,
    parameter int PKT_BYTES   = 12,
    parameter int IDENT_BYTES = 512,
    localparam int WORDS      = BUF_BYTES / 2,
    localparam int AW         = $clog2(WORDS),
    localparam int LEN_W      = $clog2(BUF_BYTES) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [7:0]    cmd_byte,
    input  logic [1:0]    drive_kind,
    input  logic          irq_disable,
    input  logic          data_we,
    input  logic [15:0]   data_wdata,
    input  logic          data_re,
    output logic [15:0]   data_rdata,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [15:0]   fill_data,
    input  logic [AW-1:0] hnd_addr,
    output logic [15:0]   hnd_rdata,
    output logic [7:0]    status,
    output logic [7:0]    error,
    output logic [7:0]    sector_count,
    output logic [7:0]    sector_num,
    output logic [15:0]   cylinder,
    output logic          irq,
    output logic          pkt_ready
);
    logic             load, pkt_mode, wr_take, rd_done, lo_valid, hi_valid;
    logic [LEN_W-1:0] load_len, xfer_idx, xfer_len;
    logic [AW-1:0]    word_addr;
    logic [15:0]      buf_word;

    ata_cmd_decode #(
        .LEN_W(LEN_W), .PKT_BYTES(PKT_BYTES), .IDENT_BYTES(IDENT_BYTES)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .drive_kind(drive_kind), .irq_disable(irq_disable), .rd_done(rd_done),
        .status(status), .error(error), .sector_count(sector_count),
        .sector_num(sector_num), .cylinder(cylinder), .irq(irq),
        .pkt_mode(pkt_mode), .load(load), .load_len(load_len)
    );

    ata_xfer_ctrl #(.LEN_W(LEN_W), .AW(AW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .load(load), .load_len(load_len),
        .data_we(data_we), .data_re(data_re), .pkt_mode(pkt_mode),
        .idx(xfer_idx), .len(xfer_len), .word_addr(word_addr),
        .wr_take(wr_take), .rd_done(rd_done), .lo_valid(lo_valid),
        .hi_valid(hi_valid), .pkt_ready(pkt_ready)
    );

    ata_xfer_buffer #(.WORDS(WORDS)) u_buf (
        .clk(clk),
        .a_we(wr_take), .a_addr(word_addr), .a_data(data_wdata),
        .b_we(fill_we), .b_addr(fill_addr), .b_data(fill_data),
        .r_addr(word_addr), .r_data(buf_word),
        .h_addr(hnd_addr), .h_data(hnd_rdata)
    );

    // Zero any read byte that lies at or beyond the transfer length.
    always_comb begin
        data_rdata[7:0]  = lo_valid ? buf_word[7:0]  : 8'h00;
        data_rdata[15:8] = hi_valid ? buf_word[15:8] : 8'h00;
    end
endmodule

// File: rtl/ata_pio_checker.sv
// Property checker for ata_cmd_pio_engine, bound into every instance.
// Relies on the top's exclusivity assumptions for data_re, data_we and cmd_we.
module ata_pio_checker #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [7:0]       cmd_byte,
    input logic [1:0]       drive_kind,
    input logic             irq_disable,
    input logic             data_we,
    input logic             data_re,
    input logic [15:0]      data_rdata,
    input logic [7:0]       status,
    input logic [7:0]       error,
    input logic             irq,
    input logic             pkt_ready,
    input logic [LEN_W-1:0] xfer_idx,
    input logic [LEN_W-1:0] xfer_len
);
    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_disable |=> !irq);

    a_r4_ident_status: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hA1) |=> (status == 8'h58 && error == 8'h00));

    a_r3_packet_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hA0 && drive_kind != 2'd1)
        |=> (status == 8'h41 && error == 8'h04));

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |=> !pkt_ready);

    a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && !data_we && xfer_idx >= xfer_len) |-> (data_rdata == 16'h0000));

    a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_idx <= xfer_len);

    a_r9_drq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && !data_we && !cmd_we && xfer_idx < xfer_len
         && (xfer_len - xfer_idx) <= LEN_W'(2)) |=> !status[3]);
endmodule

bind ata_cmd_pio_engine ata_pio_checker #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .drive_kind(drive_kind), .irq_disable(irq_disable), .data_we(data_we),
    .data_re(data_re), .data_rdata(data_rdata), .status(status),
    .error(error), .irq(irq), .pkt_ready(pkt_ready),
    .xfer_idx(xfer_idx), .xfer_len(xfer_len)
);

// File: tb/sim_ata_cmd_pio_engine.sv
`timescale 1ns/1ps
module sim_ata_cmd_pio_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [1:0]  drive_kind = 2'd1;
    logic        irq_disable = 1'b0;
    logic        data_we = 1'b0;
    logic [15:0] data_wdata = 16'h0;
    logic        data_re = 1'b0;
    logic [15:0] data_rdata;
    logic        fill_we = 1'b0;
    logic [9:0]  fill_addr = 10'd0;
    logic [15:0] fill_data = 16'h0;
    logic [9:0]  hnd_addr = 10'd0;
    logic [15:0] hnd_rdata;
    logic [7:0]  status, error, sector_count, sector_num;
    logic [15:0] cylinder;
    logic        irq, pkt_ready;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ata_cmd_pio_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .drive_kind(drive_kind), .irq_disable(irq_disable),
        .data_we(data_we), .data_wdata(data_wdata), .data_re(data_re),
        .data_rdata(data_rdata), .fill_we(fill_we), .fill_addr(fill_addr),
        .fill_data(fill_data), .hnd_addr(hnd_addr), .hnd_rdata(hnd_rdata),
        .status(status), .error(error), .sector_count(sector_count),
        .sector_num(sector_num), .cylinder(cylinder), .irq(irq),
        .pkt_ready(pkt_ready)
    );

    function automatic logic [15:0] pat(input int i);
        return {8'(i) ^ 8'h5A, 8'(i)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue_cmd(input logic [7:0] op);
        @(negedge clk); cmd_we = 1'b1; cmd_byte = op;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] w);
        @(negedge clk); data_we = 1'b1; data_wdata = w;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] v);
        @(negedge clk); data_re = 1'b1; #1 v = data_rdata;
        @(negedge clk); data_re = 1'b0;
    endtask

    task automatic fill_word(input int a, input logic [15:0] d);
        @(negedge clk); fill_we = 1'b1; fill_addr = 10'(a); fill_data = d;
        @(negedge clk); fill_we = 1'b0;
    endtask

    task automatic peek(input int a, output logic [15:0] v);
        hnd_addr = 10'(a); #1 v = hnd_rdata;
    endtask

    task automatic t_reset;
        chk("R1 status", status, 8'h50);
        chk("R1 error", error, 8'h01);
        chk("R1 sector_count", sector_count, 8'd1);
        chk("R1 sector_num", sector_num, 8'd1);
        chk("R1 cylinder", cylinder, 16'h0000);
        chk("R1 irq", irq, 1'b0);
        chk("R1 pkt_ready", pkt_ready, 1'b0);
    endtask

    task automatic t_identify;
        logic [15:0] v;
        for (int i = 0; i < 256; i++) fill_word(i, pat(i));
        peek(3, v);
        chk("R12 handler read", v, pat(3));
        drive_kind = 2'd1; irq_disable = 1'b0;
        issue_cmd(8'hA1);
        chk("R4 status", status, 8'h58);
        chk("R4 error", error, 8'h00);
        chk("R10 irq pulse", irq, 1'b1);
        @(negedge clk);
        chk("R10 irq one cycle", irq, 1'b0);
        for (int i = 0; i < 256; i++) begin
            if (i == 255) chk("R9 drq before last", status[3], 1'b1);
            rd_word(v);
            chk("R11 R8 identify word", v, pat(i));
        end
        chk("R9 drq cleared", status, 8'h50);
        rd_word(v);
        chk("R8 read past end", v, 16'h0000);
        chk("R8 status unchanged", status, 8'h50);
    endtask

    task automatic t_packet;
        logic [15:0] v;
        drive_kind = 2'd1;
        issue_cmd(8'hA0);
        chk("R2 status", status, 8'h58);
        chk("R2 sector_count", sector_count, 8'd1);
        chk("R2 no irq", irq, 1'b0);
        for (int k = 0; k < 6; k++) begin
            wr_word(16'h1100 + 16'(k));
            chk("R7 pkt_ready timing", pkt_ready, (k == 5) ? 1'b1 : 1'b0);
        end
        @(negedge clk);
        chk("R7 pkt_ready one cycle", pkt_ready, 1'b0);
        wr_word(16'hDEAD);
        chk("R7 no strobe past end", pkt_ready, 1'b0);
        for (int k = 0; k < 6; k++) begin
            peek(k, v);
            chk("R6 packet word stored", v, 16'h1100 + 16'(k));
        end
        peek(6, v);
        chk("R6 write past end ignored", v, pat(6));
    endtask

    task automatic t_abort;
        drive_kind = 2'd0;
        issue_cmd(8'hA0);
        chk("R3 A0 on disk status", status, 8'h41);
        chk("R3 A0 on disk error", error, 8'h04);
        chk("R3 abort irq", irq, 1'b1);
        issue_cmd(8'hA1);
        irq_disable = 1'b1;
        issue_cmd(8'h20);
        chk("R3 unknown code status", status, 8'h41);
        chk("R3 unknown code error", error, 8'h04);
        chk("R10 irq masked", irq, 1'b0);
        irq_disable = 1'b0;
    endtask

    task automatic t_identify_reset;
        logic [15:0] v;
        drive_kind = 2'd1;
        issue_cmd(8'hA1);
        issue_cmd(8'hEC);
        chk("R5 cylinder packet", cylinder, 16'hEB14);
        chk("R5 sector_count", sector_count, 8'd1);
        chk("R5 sector_num", sector_num, 8'd1);
        chk("R5 abort status", status, 8'h41);
        chk("R5 abort irq", irq, 1'b1);
        rd_word(v);
        chk("R5 length zero read", v, 16'h0000);
        drive_kind = 2'd0;
        issue_cmd(8'hEC);
        chk("R3 EC on disk keeps cylinder", cylinder, 16'hEB14);
        chk("R3 EC on disk status", status, 8'h41);
        drive_kind = 2'd2;
        issue_cmd(8'hEC);
        chk("R5 cylinder absent", cylinder, 16'h0000);
        chk("R5 absent error", error, 8'h04);
    endtask

    task automatic t_fill_priority;
        logic [15:0] v;
        drive_kind = 2'd1;
        issue_cmd(8'hA0);
        @(negedge clk);
        data_we = 1'b1; data_wdata = 16'hAAAA;
        fill_we = 1'b1; fill_addr = 10'd0; fill_data = 16'hBBBB;
        @(negedge clk);
        data_we = 1'b0; fill_we = 1'b0;
        peek(0, v);
        chk("R11 data write wins", v, 16'hAAAA);
        fill_word(20, 16'h1234);
        peek(20, v);
        chk("R11 fill alone", v, 16'h1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_identify;
        t_packet;
        t_abort;
        t_identify_reset;
        t_fill_priority;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule